// File: doc/BRIEF.md
# Peripheral Input Routing Matrix

This block decides, for every peripheral input port on the chip, where that port's signal comes from. Each port has its own small configuration register. The register chooses one of three sources for the port: any one of the synchronized pin inputs, a forced constant, or a fixed direct-path signal that bypasses the matrix. The register can also invert the value chosen from the matrix.

Software writes a port's register through a simple single-cycle register bus and can read it back on the same bus. The port outputs are combinational from the stored configuration, the pin vector and the direct vector. A write therefore changes the routing from the clock edge that stores it. Input synchronization and interrupt generation live outside this block.

Top module: `inmux_top`

## Requirements
- R1: After reset every configuration register reads as zero, and every port output equals its direct-path input.
- R2: When the route-enable bit (bit 7) of a port's register is 0, the port output equals that port's direct-path input, whatever the selector and invert bits hold.
- R3: When route-enable is 1 and the selector (bits 5:0) holds a value p below the pin count, the port output follows pin p, and it tracks later changes on that pin.
- R4: Selector code 0x38 with route-enable set drives the port high when the invert bit is 0.
- R5: Selector code 0x3C with route-enable set drives the port low when the invert bit is 0.
- R6: Any other selector code at or above the pin count, with route-enable set, drives the port low when the invert bit is 0.
- R7: The invert bit (bit 6) is applied after source selection, so an inverted forced-high port reads low and an inverted forced-low port reads high. It has no effect while route-enable is 0.
- R8: A write stores bits 7:0 of the write data. A read of the same register returns those bits, with bits 31:8 read as zero whatever was written there.
- R9: A write to one port's register leaves the registers of all other ports unchanged.
- R10: A port's output reflects a new configuration as soon as the clock edge that accepts the write has passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWr | input | 1 | Write strobe for the configuration register at cfgAddr |
| cfgAddr | input | ADDR_W | Index of the port whose register is written or read |
| cfgWdata | input | 32 | Write data; only bits 7:0 are kept |
| cfgRdata | output | 32 | Read data for the register at cfgAddr |
| padIn | input | NUM_PINS | Synchronized pin input values |
| directIn | input | NUM_PORTS | Direct-path signal for each port |
| periphIn | output | NUM_PORTS | Signal delivered to each peripheral input port |

## Verification
The bench builds the block with 16 ports and the full 30 pins. With 16 ports, every port gets its own distinct configuration and can be checked for isolation in a short run. Keeping all 30 pins makes the top pin index (29), the first unused code (30), the largest code (63) and both constant codes reachable. Pins are driven with an alternating pattern and the direct path with a mixed pattern, so every routing choice yields a value that tells the sources apart.

// File: rtl/inmux_pkg.sv
package inmux_pkg;
  localparam int SEL_W = 6;
  localparam logic [SEL_W-1:0] CODE_HIGH = 6'h38;
  localparam logic [SEL_W-1:0] CODE_LOW  = 6'h3C;

  // Stored per-port configuration; bit order equals the register layout
  typedef struct packed {
    logic             routeEn;  // bit 7
    logic             invert;   // bit 6
    logic [SEL_W-1:0] sel;      // bits 5:0
  } cfgT;

  localparam int CFG_W = $bits(cfgT);

  // Strobes from control to datapath
  typedef struct packed {
    logic wrEn;
    cfgT  wrData;
  } strobeT;
endpackage

// File: rtl/inmux_ctrl.sv
module inmux_ctrl
  import inmux_pkg::*;
#(
  parameter int NUM_PORTS = 128,
  parameter int ADDR_W    = $clog2(NUM_PORTS)
) (
  input  logic              cfgWr,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [31:0]       cfgWdata,
  input  cfgT               rdCfg,
  output strobeT            stb,
  output logic [31:0]       cfgRdata
);
  logic inRange;

  always_comb begin
    inRange     = (int'(cfgAddr) < NUM_PORTS);
    stb.wrEn    = cfgWr && inRange;
    stb.wrData  = cfgT'(cfgWdata[CFG_W-1:0]);
    cfgRdata    = '0;
    if (inRange) cfgRdata[CFG_W-1:0] = rdCfg;
  end
endmodule

// File: rtl/inmux_datapath.sv
module inmux_datapath
  import inmux_pkg::*;
#(
  parameter int NUM_PORTS = 128,
  parameter int NUM_PINS  = 30,
  parameter int ADDR_W    = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobeT               stb,
  input  logic [ADDR_W-1:0]    wrIdx,
  input  logic [ADDR_W-1:0]    rdIdx,
  output cfgT                  rdCfg,
  input  logic [NUM_PINS-1:0]  padIn,
  input  logic [NUM_PORTS-1:0] directIn,
  output logic [NUM_PORTS-1:0] periphIn
);
  cfgT [NUM_PORTS-1:0] cfgMem;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cfgMem <= '0;
    else if (stb.wrEn)  cfgMem[wrIdx] <= stb.wrData;
  end

  assign rdCfg = cfgMem[rdIdx];

  // R8
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrEn |=> cfgMem[$past(wrIdx)] == $past(stb.wrData));

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrEn |=> $stable(cfgMem));

  for (genvar g = 0; g < NUM_PORTS; g++) begin : gPort
    logic srcVal;

    always_comb begin
      srcVal = (cfgMem[g].sel == CODE_HIGH);
      for (int p = 0; p < NUM_PINS; p++) begin
        if (cfgMem[g].sel == SEL_W'(p)) srcVal = padIn[p];
      end
    end

    assign periphIn[g] = cfgMem[g].routeEn ? (srcVal ^ cfgMem[g].invert)
                                           : directIn[g];

    // R2
    bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
      !cfgMem[g].routeEn |-> periphIn[g] == directIn[g]);

    // R4
    const_high_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cfgMem[g].routeEn && cfgMem[g].sel == CODE_HIGH) |->
        periphIn[g] == !cfgMem[g].invert);

    // R5
    const_low_chk: assert property (@(posedge clk) disable iff (!rstN)
      (cfgMem[g].routeEn && cfgMem[g].sel == CODE_LOW) |->
        periphIn[g] == cfgMem[g].invert);
  end
endmodule

// File: rtl/inmux_top.sv
module inmux_top
  import inmux_pkg::*;
#(
  parameter int NUM_PORTS = 128,
  parameter int NUM_PINS  = 30,
  localparam int ADDR_W   = $clog2(NUM_PORTS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWr,
  input  logic [ADDR_W-1:0]    cfgAddr,
  input  logic [31:0]          cfgWdata,
  output logic [31:0]          cfgRdata,
  input  logic [NUM_PINS-1:0]  padIn,
  input  logic [NUM_PORTS-1:0] directIn,
  output logic [NUM_PORTS-1:0] periphIn
);
  strobeT stb;
  cfgT    rdCfg;

  inmux_ctrl #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W)) uCtrl (
    .cfgWr(cfgWr), .cfgAddr(cfgAddr), .cfgWdata(cfgWdata),
    .rdCfg(rdCfg), .stb(stb), .cfgRdata(cfgRdata)
  );

  inmux_datapath #(.NUM_PORTS(NUM_PORTS), .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrIdx(cfgAddr), .rdIdx(cfgAddr),
    .rdCfg(rdCfg), .padIn(padIn), .directIn(directIn), .periphIn(periphIn)
  );
endmodule

// File: tb/tb_inmux_top.sv
module tb_inmux_top;
  localparam int CLK_PERIOD = 10;
  localparam int PORTS = 16;
  localparam int PINS  = 30;
  localparam int AW    = 4;
  localparam logic [PINS-1:0]  PAD_PAT = 30'h15555555; // even pins high
  localparam logic [PORTS-1:0] DIR_PAT = 16'hA5A5;
  localparam int NVEC = 15;
  // {port[3:0], cfg[7:0], expected}; cfg = {routeEn, invert, sel[5:0]}
  localparam logic [12:0] VEC [NVEC] = '{
    {4'd0,  8'h80, 1'b1},  // R3 pin0
    {4'd1,  8'h81, 1'b0},  // R3 pin1
    {4'd2,  8'hC1, 1'b1},  // R7 inverted pin1
    {4'd3,  8'h9D, 1'b0},  // R3 pin29
    {4'd4,  8'h9C, 1'b1},  // R3 pin28
    {4'd5,  8'hB8, 1'b1},  // R4
    {4'd6,  8'hF8, 1'b0},  // R7 inverted high
    {4'd7,  8'hBC, 1'b0},  // R5
    {4'd8,  8'hFC, 1'b1},  // R7 inverted low
    {4'd9,  8'h9E, 1'b0},  // R6 code 30
    {4'd10, 8'hDE, 1'b1},  // R6/R7 inverted code 30
    {4'd11, 8'h3F, 1'b0},  // R2 direct bit11
    {4'd12, 8'h78, 1'b0},  // R2/R7 invert ignored
    {4'd13, 8'h40, 1'b1},  // R2 direct bit13
    {4'd15, 8'hBF, 1'b0}   // R6 code 63
  };

  logic clk = 0;
  logic rstN = 0;
  logic cfgWr = 0;
  logic [AW-1:0] cfgAddr = '0;
  logic [31:0] cfgWdata = '0;
  logic [31:0] cfgRdata;
  logic [PINS-1:0] padIn = PAD_PAT;
  logic [PORTS-1:0] directIn = DIR_PAT;
  logic [PORTS-1:0] periphIn;
  int nRun = 0;
  int nFail = 0;
  logic done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  inmux_top #(.NUM_PORTS(PORTS), .NUM_PINS(PINS)) dut (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .cfgRdata(cfgRdata), .padIn(padIn),
    .directIn(directIn), .periphIn(periphIn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeCfg(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgWr = 1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWr = 0;
  endtask

  task automatic readCfg(input logic [AW-1:0] a, output logic [31:0] d);
    cfgAddr = a;
    #1;
    d = cfgRdata;
  endtask

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int i = 0; i < PORTS; i++) begin
      readCfg(AW'(i), rd);
      check("R1 reset readback", rd, 32'h0);
    end
    check("R1 reset outputs", 32'(periphIn), 32'(DIR_PAT));
    rstN = 1;
    @(negedge clk);

    // table walk: R10 sampled at the negedge right after the accepting edge
    for (int v = 0; v < NVEC; v++) begin
      writeCfg(VEC[v][12:9], {24'h0, VEC[v][8:1]});
      check("R10 output after write", 32'(periphIn[VEC[v][12:9]]), 32'(VEC[v][0]));
      readCfg(VEC[v][12:9], rd);
      check("R8 readback", rd, {24'h0, VEC[v][8:1]});
    end

    // R9: earlier entries untouched by later writes
    readCfg(4'd0, rd);  check("R9 port0 kept", rd, 32'h80);
    readCfg(4'd14, rd); check("R9 port14 untouched", rd, 32'h0);

    // R8: upper write bits dropped
    writeCfg(4'd14, 32'hFFFF_FF81);
    readCfg(4'd14, rd); check("R8 upper bits zero", rd, 32'h81);
    check("R3 port14 pin1", 32'(periphIn[14]), 32'h0);

    // R3: tracks pin changes
    padIn[0] = 1'b0; #1;
    check("R3 follows pin0 low", 32'(periphIn[0]), 32'h0);
    padIn[29] = 1'b1; #1;
    check("R3 follows pin29 high", 32'(periphIn[3]), 32'h1);

    // R2: direct toggle reaches bypassed port, not routed port
    directIn[11] = 1'b1; directIn[0] = 1'b0; #1;
    check("R2 direct reaches port11", 32'(periphIn[11]), 32'h1);
    check("R2 direct ignored on routed port0", 32'(periphIn[0]), 32'h0);

    // R6: pin changes do not disturb unused code
    padIn = '1; #1;
    check("R6 code30 stays low", 32'(periphIn[9]), 32'h0);
    check("R4 still high", 32'(periphIn[5]), 32'h1);
    check("R5 still low", 32'(periphIn[7]), 32'h0);

    // R1: reset again clears configuration
    rstN = 0; #1;
    readCfg(4'd5, rd); check("R1 reset clears", rd, 32'h0);
    check("R1 outputs direct after reset", 32'(periphIn), 32'(directIn));

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule